// File: doc/BRIEF.md
# Register-Pair Doubleword Access Sequencer

This block executes a 64-bit load or store on a 32-bit core whose registers and data-memory port are both one word wide. It takes one decoded doubleword instruction through a valid/ready issue handshake. It reads the base register and, for a store, the two source registers. It checks the instruction and forms the effective address. It then runs the access as two single-word memory transactions in sequence: the low word first at the effective address, then the high word at the address four bytes above.

For a load, the first returned word is held in a staging register until the second beat returns. Both words are then written into an even/odd register pair through two write ports that share one enable. If either beat returns an error, nothing is written and an access fault is reported. For a store, memory is not restored: a word already written by the first beat stays in place if the second beat faults.

Several faults are caught before any memory traffic starts: an odd data register, a misaligned address, and an address that touches a configurable non-idempotent region. Each one ends the instruction with an exception and issues no beat.

Top module: `pair_mem_seq`

## Requirements
- R1: An instruction is a doubleword load when bits 6:0 equal 0x03 and bits 14:12 equal 3. It is a doubleword store when bits 6:0 equal 0x23 and bits 14:12 equal 3. Any other encoding, or any encoding when the parameter ENABLE_PAIR is 0, retires with exc_valid high, exc_cause 2 (illegal) and no memory beat.
- R2: The effective address is the base register (bits 19:15) plus a sign-extended 12-bit offset. For a load the offset is bits 31:20. For a store it is bits 31:25 followed by bits 11:7. Beat 0 goes to that address and beat 1 to that address plus 4, in that order.
- R3: An odd data register number (load destination in bits 11:7, store source in bits 24:20) retires with exc_cause 2 and no memory beat.
- R4: An effective address with bits 1:0 not zero retires with no memory beat. The cause is 4 for a load and 6 for a store. An illegal encoding takes priority over this check.
- R5: When either word address falls in the region selected by REGION_BASE/REGION_MASK, the instruction retires with no memory beat. The cause is 5 for a load and 7 for a store. Misalignment takes priority over this check.
- R6: A load that completes without error raises rf_we for exactly one cycle. In that cycle the low port writes register rd with the beat 0 word, and the high port writes register rd+1 with the beat 1 word.
- R7: A load with an error response on either beat retires with exc_cause 5 and rf_we low. An error on beat 0 means beat 1 is never issued.
- R8: A store writes the value of register rs2 at the effective address and the value of rs2+1 at the address plus 4. An error on beat 0 ends it with exc_cause 7 after one beat. An error on beat 1 ends it with exc_cause 7, and the first word stays written.
- R9: A load with destination x0 still performs both beats, retires without exception, and writes no register.
- R10: issue_ready is high only when the block is idle. At most one memory request is open at a time, and a request is held stable until it is accepted. retire pulses for one cycle per instruction, and exc_valid and rf_we are only ever high in that cycle and never together.
- R11: After reset, issue_ready is high and mem_req_valid, rf_we, retire and exc_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Block idle, instruction taken when valid |
| issue_instr | input | 32 | 32-bit instruction word |
| rf_base_addr | output | 5 | Read address for the base register |
| rf_base_data | input | 32 | Base register value |
| rf_src_lo_addr | output | 5 | Read address of the even store source |
| rf_src_lo_data | input | 32 | Even store source value (low word) |
| rf_src_hi_addr | output | 5 | Read address of the odd store source |
| rf_src_hi_data | input | 32 | Odd store source value (high word) |
| rf_we | output | 1 | Write enable shared by both write ports |
| rf_wr_lo_addr | output | 5 | Even destination register |
| rf_wr_lo_data | output | 32 | Low loaded word |
| rf_wr_hi_addr | output | 5 | Odd destination register |
| rf_wr_hi_data | output | 32 | High loaded word |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Word address of the beat |
| mem_req_wdata | output | 32 | Write data of the beat |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_err | input | 1 | Response carries an error |
| retire | output | 1 | One-cycle pulse when an instruction ends |
| exc_valid | output | 1 | Instruction ended with an exception |
| exc_cause | output | 4 | Exception cause code |

## Verification
The assertions check the handshake rules of R10 on every cycle: one request at a time, requests held stable while stalled, a one-cycle retire, and no write alongside an exception. They also check that a fault never carries a register write. The values belong to the bench's scenarios: the address arithmetic with both offset layouts, the ordering of the words in the pair, the priority among the pre-access checks, and how a beat error affects the register file and memory. These show only through the data the bench observes.

// File: rtl/pair_seq_pkg.sv
package pair_seq_pkg;
   localparam int XLEN   = 32;
   localparam int REG_AW = 5;

   localparam logic [6:0] OPC_LOAD  = 7'h03;
   localparam logic [6:0] OPC_STORE = 7'h23;
   localparam logic [2:0] F3_DOUBLE = 3'd3;

   localparam logic [3:0] CAUSE_ILLEGAL  = 4'd2;
   localparam logic [3:0] CAUSE_LD_MISAL = 4'd4;
   localparam logic [3:0] CAUSE_LD_FAULT = 4'd5;
   localparam logic [3:0] CAUSE_ST_MISAL = 4'd6;
   localparam logic [3:0] CAUSE_ST_FAULT = 4'd7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_B0_REQ,
      ST_B0_RSP,
      ST_B1_REQ,
      ST_B1_RSP,
      ST_DONE
   } seq_state_e;
endpackage

// File: rtl/pair_seq_region.sv
module pair_seq_region
   import pair_seq_pkg::*;
#(
   parameter bit                REGION_EN   = 1'b1,
   parameter logic [XLEN-1:0]   REGION_BASE = 32'h4000_0000,
   parameter logic [XLEN-1:0]   REGION_MASK = 32'hF000_0000
) (
   input  logic [XLEN-1:0] addr_lo,
   output logic            hit
);
   localparam logic [XLEN-1:0] WORD_STEP = XLEN'(XLEN / 8);

   generate
      if (REGION_EN) begin : g_region
         logic [XLEN-1:0] addr_hi;
         assign addr_hi = addr_lo + WORD_STEP;
         assign hit = ((addr_lo & REGION_MASK) == REGION_BASE) ||
                      ((addr_hi & REGION_MASK) == REGION_BASE);
      end else begin : g_no_region
         assign hit = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pair_seq_check.sv
module pair_seq_check
   import pair_seq_pkg::*;
#(
   parameter bit              ENABLE_PAIR = 1'b1,
   parameter bit              REGION_EN   = 1'b1,
   parameter logic [XLEN-1:0] REGION_BASE = 32'h4000_0000,
   parameter logic [XLEN-1:0] REGION_MASK = 32'hF000_0000
) (
   input  logic [31:0]       instr,
   input  logic [XLEN-1:0]   base_val,
   output logic              is_load,
   output logic [REG_AW-1:0] data_reg,
   output logic [XLEN-1:0]   ea,
   output logic              trap,
   output logic [3:0]        cause
);
   localparam int OFF_W = 12;

   logic              op_ld, op_st, odd_reg, misal, region_hit;
   logic [OFF_W-1:0]  offset;

   assign op_ld = ENABLE_PAIR && instr[6:0] == OPC_LOAD  && instr[14:12] == F3_DOUBLE;
   assign op_st = ENABLE_PAIR && instr[6:0] == OPC_STORE && instr[14:12] == F3_DOUBLE;
   assign is_load  = op_ld;
   assign data_reg = op_ld ? instr[11:7] : instr[24:20];
   assign offset   = op_ld ? instr[31:20] : {instr[31:25], instr[11:7]};
   assign ea       = base_val + {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};
   assign odd_reg  = data_reg[0];
   assign misal    = |ea[1:0];

   pair_seq_region #(
      .REGION_EN  (REGION_EN),
      .REGION_BASE(REGION_BASE),
      .REGION_MASK(REGION_MASK)
   ) u_region (
      .addr_lo(ea),
      .hit    (region_hit)
   );

   always_comb begin
      trap  = 1'b1;
      cause = CAUSE_ILLEGAL;
      if (!(op_ld || op_st) || odd_reg) begin
         cause = CAUSE_ILLEGAL;
      end else if (misal) begin
         cause = op_ld ? CAUSE_LD_MISAL : CAUSE_ST_MISAL;
      end else if (region_hit) begin
         cause = op_ld ? CAUSE_LD_FAULT : CAUSE_ST_FAULT;
      end else begin
         trap  = 1'b0;
         cause = '0;
      end
   end

   always_comb begin
      if (trap && !(op_ld || op_st)) begin
         assert (cause == CAUSE_ILLEGAL) else $error("AST_UNKNOWN_OP_ILLEGAL"); // R1
      end
   end
endmodule

// File: rtl/pair_seq_fsm.sv
module pair_seq_fsm
   import pair_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_trap,
   input  logic [3:0]        start_cause,
   input  logic              start_load,
   input  logic [REG_AW-1:0] start_reg,
   input  logic [XLEN-1:0]   start_ea,
   input  logic [XLEN-1:0]   start_lo,
   input  logic [XLEN-1:0]   start_hi,
   output logic              idle,
   output logic              rf_we,
   output logic [REG_AW-1:0] rf_wr_lo_addr,
   output logic [XLEN-1:0]   rf_wr_lo_data,
   output logic [REG_AW-1:0] rf_wr_hi_addr,
   output logic [XLEN-1:0]   rf_wr_hi_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic [XLEN-1:0]   mem_req_addr,
   output logic [XLEN-1:0]   mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [XLEN-1:0]   mem_rsp_data,
   input  logic              mem_rsp_err,
   output logic              retire,
   output logic              exc_valid,
   output logic [3:0]        exc_cause
);
   localparam logic [XLEN-1:0] WORD_STEP = XLEN'(XLEN / 8);

   seq_state_e        state_q;
   logic              load_q, fault_q;
   logic [3:0]        cause_q;
   logic [REG_AW-1:0] reg_q;
   logic [XLEN-1:0]   ea_q, lo_q, hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         load_q  <= 1'b0;
         fault_q <= 1'b0;
         cause_q <= '0;
         reg_q   <= '0;
         ea_q    <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               load_q  <= start_load;
               reg_q   <= start_reg;
               ea_q    <= start_ea;
               lo_q    <= start_lo;
               hi_q    <= start_hi;
               fault_q <= start_trap;
               cause_q <= start_trap ? start_cause : 4'd0;
               state_q <= start_trap ? ST_DONE : ST_B0_REQ;
            end
            ST_B0_REQ: if (mem_req_ready) state_q <= ST_B0_RSP;
            ST_B0_RSP: if (mem_rsp_valid) begin
               if (mem_rsp_err) begin
                  fault_q <= 1'b1;
                  cause_q <= load_q ? CAUSE_LD_FAULT : CAUSE_ST_FAULT;
                  state_q <= ST_DONE;
               end else begin
                  if (load_q) lo_q <= mem_rsp_data;
                  state_q <= ST_B1_REQ;
               end
            end
            ST_B1_REQ: if (mem_req_ready) state_q <= ST_B1_RSP;
            ST_B1_RSP: if (mem_rsp_valid) begin
               if (mem_rsp_err) begin
                  fault_q <= 1'b1;
                  cause_q <= load_q ? CAUSE_LD_FAULT : CAUSE_ST_FAULT;
               end else if (load_q) begin
                  hi_q <= mem_rsp_data;
               end
               state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign idle          = state_q == ST_IDLE;
   assign mem_req_valid = state_q == ST_B0_REQ || state_q == ST_B1_REQ;
   assign mem_req_we    = !load_q;
   assign mem_req_addr  = (state_q == ST_B1_REQ) ? ea_q + WORD_STEP : ea_q;
   assign mem_req_wdata = (state_q == ST_B1_REQ) ? hi_q : lo_q;
   assign retire        = state_q == ST_DONE;
   assign exc_valid     = retire && fault_q;
   assign exc_cause     = cause_q;
   assign rf_we         = retire && !fault_q && load_q && reg_q != '0;
   assign rf_wr_lo_addr = reg_q;
   assign rf_wr_hi_addr = reg_q | REG_AW'(1);
   assign rf_wr_lo_data = lo_q;
   assign rf_wr_hi_data = hi_q;

   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !mem_req_valid) else $error("AST_IDLE_NO_REQ"); // R10
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
                                          && $stable(mem_req_wdata)) else $error("AST_REQ_HELD"); // R10
   AST_RETIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      retire |=> !retire && idle) else $error("AST_RETIRE_PULSE"); // R10
   AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> !rf_we) else $error("AST_FAULT_NO_WRITE"); // R7
   AST_WRITE_AT_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> retire && !mem_req_valid) else $error("AST_WRITE_AT_RETIRE"); // R6
   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !idle) else $error("AST_ACCEPT_BUSY"); // R10
endmodule

// File: rtl/pair_mem_seq.sv
module pair_mem_seq
   import pair_seq_pkg::*;
#(
   parameter bit              ENABLE_PAIR = 1'b1,
   parameter bit              REGION_EN   = 1'b1,
   parameter logic [XLEN-1:0] REGION_BASE = 32'h4000_0000,
   parameter logic [XLEN-1:0] REGION_MASK = 32'hF000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   output logic              issue_ready,
   input  logic [31:0]       issue_instr,
   output logic [REG_AW-1:0] rf_base_addr,
   input  logic [XLEN-1:0]   rf_base_data,
   output logic [REG_AW-1:0] rf_src_lo_addr,
   input  logic [XLEN-1:0]   rf_src_lo_data,
   output logic [REG_AW-1:0] rf_src_hi_addr,
   input  logic [XLEN-1:0]   rf_src_hi_data,
   output logic              rf_we,
   output logic [REG_AW-1:0] rf_wr_lo_addr,
   output logic [XLEN-1:0]   rf_wr_lo_data,
   output logic [REG_AW-1:0] rf_wr_hi_addr,
   output logic [XLEN-1:0]   rf_wr_hi_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic [XLEN-1:0]   mem_req_addr,
   output logic [XLEN-1:0]   mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [XLEN-1:0]   mem_rsp_data,
   input  logic              mem_rsp_err,
   output logic              retire,
   output logic              exc_valid,
   output logic [3:0]        exc_cause
);
   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("pair_mem_seq: word width must be 32");
      end
      if ((REGION_BASE & ~REGION_MASK) != '0) begin : g_bad_region
         $error("pair_mem_seq: REGION_BASE has bits outside REGION_MASK");
      end
   endgenerate

   logic              chk_load, chk_trap, start;
   logic [REG_AW-1:0] chk_reg;
   logic [XLEN-1:0]   chk_ea;
   logic [3:0]        chk_cause;

   assign rf_base_addr   = issue_instr[19:15];
   assign rf_src_lo_addr = issue_instr[24:20];
   assign rf_src_hi_addr = {issue_instr[24:21], 1'b1};

   pair_seq_check #(
      .ENABLE_PAIR(ENABLE_PAIR),
      .REGION_EN  (REGION_EN),
      .REGION_BASE(REGION_BASE),
      .REGION_MASK(REGION_MASK)
   ) u_check (
      .instr   (issue_instr),
      .base_val(rf_base_data),
      .is_load (chk_load),
      .data_reg(chk_reg),
      .ea      (chk_ea),
      .trap    (chk_trap),
      .cause   (chk_cause)
   );

   assign start = issue_valid && issue_ready;

   pair_seq_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .start_trap   (chk_trap),
      .start_cause  (chk_cause),
      .start_load   (chk_load),
      .start_reg    (chk_reg),
      .start_ea     (chk_ea),
      .start_lo     (rf_src_lo_data),
      .start_hi     (rf_src_hi_data),
      .idle         (issue_ready),
      .rf_we        (rf_we),
      .rf_wr_lo_addr(rf_wr_lo_addr),
      .rf_wr_lo_data(rf_wr_lo_data),
      .rf_wr_hi_addr(rf_wr_hi_addr),
      .rf_wr_hi_data(rf_wr_hi_data),
      .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready),
      .mem_req_we   (mem_req_we),
      .mem_req_addr (mem_req_addr),
      .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data),
      .mem_rsp_err  (mem_rsp_err),
      .retire       (retire),
      .exc_valid    (exc_valid),
      .exc_cause    (exc_cause)
   );

   AST_TRAP_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      start && chk_trap |=> !mem_req_valid) else $error("AST_TRAP_NO_BEAT"); // R3
   AST_RETIRE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> exc_cause != 4'd0) else $error("AST_RETIRE_CAUSE"); // R10
endmodule

// File: tb/pair_mem_seq_test.sv
module pair_mem_seq_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_valid = 1'b0;
   logic        issue_ready;
   logic [31:0] issue_instr = 32'h0;
   logic [4:0]  rf_base_addr, rf_src_lo_addr, rf_src_hi_addr;
   logic [31:0] rf_base_data, rf_src_lo_data, rf_src_hi_data;
   logic        rf_we;
   logic [4:0]  rf_wr_lo_addr, rf_wr_hi_addr;
   logic [31:0] rf_wr_lo_data, rf_wr_hi_data;
   logic        mem_req_valid, mem_req_we;
   logic        mem_req_ready = 1'b1;
   logic [31:0] mem_req_addr, mem_req_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = 32'h0;
   logic        mem_rsp_err = 1'b0;
   logic        retire, exc_valid;
   logic [3:0]  exc_cause;

   always #(CLK_PERIOD/2) clk = ~clk;

   pair_mem_seq uut (.*);

   logic [31:0] regs [0:31];
   logic [31:0] mem [0:63];
   logic [31:0] err_addr = 32'hFFFF_FFF0;
   logic        pl_en = 1'b0;
   logic [5:0]  pl_idx = '0;
   logic [31:0] pl_data = '0;
   int          beat_total = 0;
   logic [31:0] addr_log [0:255];

   assign rf_base_data   = regs[rf_base_addr];
   assign rf_src_lo_data = regs[rf_src_lo_addr];
   assign rf_src_hi_data = regs[rf_src_hi_addr];

   always @(posedge clk) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
      if (pl_en) mem[pl_idx] <= pl_data;
      if (mem_req_valid && mem_req_ready) begin
         mem_rsp_valid <= 1'b1;
         mem_rsp_err   <= (mem_req_addr == err_addr);
         mem_rsp_data  <= mem[mem_req_addr[7:2]];
         if (mem_req_we && mem_req_addr != err_addr) mem[mem_req_addr[7:2]] <= mem_req_wdata;
         addr_log[beat_total[7:0]] <= mem_req_addr;
         beat_total <= beat_total + 1;
      end
   end

   int n_checks = 0;
   int n_fail = 0;

   // results of the last run_op
   int          r_beats;
   logic [31:0] r_a0, r_a1;
   logic        r_we, r_exc;
   logic [3:0]  r_cause;
   logic [4:0]  r_lo_a, r_hi_a;
   logic [31:0] r_lo_d, r_hi_d;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_ld(input logic [4:0] rd, input logic [4:0] rs1, input logic [11:0] imm);
      return {imm, rs1, 3'd3, rd, 7'h03};
   endfunction

   function automatic logic [31:0] enc_sd(input logic [4:0] rs2, input logic [4:0] rs1, input logic [11:0] imm);
      return {imm[11:5], rs2, rs1, 3'd3, imm[4:0], 7'h23};
   endfunction

   task automatic preload(input logic [31:0] addr, input logic [31:0] data);
      @(negedge clk);
      pl_en = 1'b1; pl_idx = addr[7:2]; pl_data = data;
      @(negedge clk);
      pl_en = 1'b0;
   endtask

   function automatic logic [31:0] mem_at(input logic [31:0] addr);
      return mem[addr[7:2]];
   endfunction

   task automatic run_op(input logic [31:0] ins);
      int start_cnt;
      int waited;
      @(negedge clk);
      start_cnt   = beat_total;
      issue_instr = ins;
      issue_valid = 1'b1;
      @(negedge clk);
      issue_valid = 1'b0;
      waited = 0;
      while (!retire && waited < 50) begin
         @(negedge clk);
         waited++;
      end
      if (!retire) chk("R10", "retire seen", 32'd0, 32'd1);
      r_we    = rf_we;
      r_exc   = exc_valid;
      r_cause = exc_cause;
      r_lo_a  = rf_wr_lo_addr;
      r_hi_a  = rf_wr_hi_addr;
      r_lo_d  = rf_wr_lo_data;
      r_hi_d  = rf_wr_hi_data;
      r_beats = beat_total - start_cnt;
      r_a0    = addr_log[start_cnt[7:0]];
      r_a1    = addr_log[8'(start_cnt + 1)];
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R11", "issue_ready", 32'(issue_ready), 32'd1);
      chk("R11", "mem_req_valid", 32'(mem_req_valid), 32'd0);
      chk("R11", "rf_we", 32'(rf_we), 32'd0);
      chk("R11", "retire", 32'(retire), 32'd0);
      chk("R11", "exc_valid", 32'(exc_valid), 32'd0);
   endtask

   task automatic t_load_basic;
      preload(32'h28, 32'hA1A1_0001);
      preload(32'h2C, 32'hB2B2_0002);
      run_op(enc_ld(5'd10, 5'd5, 12'd8));
      chk("R2", "beat0 addr", r_a0, 32'h28);
      chk("R2", "beat1 addr", r_a1, 32'h2C);
      chk("R6", "we", 32'(r_we), 32'd1);
      chk("R6", "exc", 32'(r_exc), 32'd0);
      chk("R6", "lo addr", 32'(r_lo_a), 32'd10);
      chk("R6", "hi addr", 32'(r_hi_a), 32'd11);
      chk("R6", "lo data", r_lo_d, 32'hA1A1_0001);
      chk("R6", "hi data", r_hi_d, 32'hB2B2_0002);
   endtask

   task automatic t_load_negoff;
      preload(32'h30, 32'h1111_3030);
      preload(32'h34, 32'h2222_3434);
      run_op(enc_ld(5'd12, 5'd6, 12'hFF0));
      chk("R2", "neg offset beat0", r_a0, 32'h30);
      chk("R2", "neg offset beats", 32'(r_beats), 32'd2);
      chk("R6", "neg offset lo", r_lo_d, 32'h1111_3030);
      chk("R6", "neg offset hi", r_hi_d, 32'h2222_3434);
   endtask

   task automatic t_store_basic;
      run_op(enc_sd(5'd14, 5'd7, 12'h044));
      chk("R2", "store beat0 addr", r_a0, 32'h94);
      chk("R2", "store beat1 addr", r_a1, 32'h98);
      chk("R8", "store exc", 32'(r_exc), 32'd0);
      chk("R8", "store no rf write", 32'(r_we), 32'd0);
      chk("R8", "store low word", mem_at(32'h94), 32'hC0C0_1414);
      chk("R8", "store high word", mem_at(32'h98), 32'hD0D0_1515);
   endtask

   task automatic t_illegal;
      run_op(enc_ld(5'd11, 5'd5, 12'd8));
      chk("R3", "odd rd cause", 32'(r_cause), 32'd2);
      chk("R3", "odd rd beats", 32'(r_beats), 32'd0);
      chk("R3", "odd rd we", 32'(r_we), 32'd0);
      run_op(enc_sd(5'd13, 5'd7, 12'd0));
      chk("R3", "odd rs2 cause", 32'(r_cause), 32'd2);
      chk("R3", "odd rs2 beats", 32'(r_beats), 32'd0);
      run_op({12'd8, 5'd5, 3'd2, 5'd10, 7'h03});
      chk("R1", "funct3=2 exc", 32'(r_exc), 32'd1);
      chk("R1", "funct3=2 cause", 32'(r_cause), 32'd2);
      chk("R1", "funct3=2 beats", 32'(r_beats), 32'd0);
      run_op({12'd8, 5'd5, 3'd3, 5'd10, 7'h13});
      chk("R1", "other opcode cause", 32'(r_cause), 32'd2);
      // illegal wins over misalignment
      run_op(enc_ld(5'd11, 5'd5, 12'd2));
      chk("R4", "odd+misal cause", 32'(r_cause), 32'd2);
   endtask

   task automatic t_misaligned;
      run_op(enc_ld(5'd10, 5'd5, 12'd2));
      chk("R4", "load misal cause", 32'(r_cause), 32'd4);
      chk("R4", "load misal beats", 32'(r_beats), 32'd0);
      run_op(enc_sd(5'd14, 5'd7, 12'd1));
      chk("R4", "store misal cause", 32'(r_cause), 32'd6);
      chk("R4", "store misal beats", 32'(r_beats), 32'd0);
      // misalignment wins over the region check
      run_op(enc_ld(5'd10, 5'd8, 12'd2));
      chk("R5", "misal+region cause", 32'(r_cause), 32'd4);
   endtask

   task automatic t_region;
      run_op(enc_ld(5'd10, 5'd8, 12'd0));
      chk("R5", "region load cause", 32'(r_cause), 32'd5);
      chk("R5", "region load beats", 32'(r_beats), 32'd0);
      run_op(enc_sd(5'd14, 5'd8, 12'd8));
      chk("R5", "region store cause", 32'(r_cause), 32'd7);
      chk("R5", "region store beats", 32'(r_beats), 32'd0);
      run_op(enc_ld(5'd10, 5'd9, 12'd0));
      chk("R5", "high word in region cause", 32'(r_cause), 32'd5);
      chk("R5", "high word in region beats", 32'(r_beats), 32'd0);
   endtask

   task automatic t_load_fault;
      err_addr = 32'h2C;
      run_op(enc_ld(5'd10, 5'd5, 12'd8));
      chk("R7", "beat1 err cause", 32'(r_cause), 32'd5);
      chk("R7", "beat1 err we", 32'(r_we), 32'd0);
      chk("R7", "beat1 err beats", 32'(r_beats), 32'd2);
      err_addr = 32'h28;
      run_op(enc_ld(5'd10, 5'd5, 12'd8));
      chk("R7", "beat0 err cause", 32'(r_cause), 32'd5);
      chk("R7", "beat0 err we", 32'(r_we), 32'd0);
      chk("R7", "beat0 err beats", 32'(r_beats), 32'd1);
      err_addr = 32'hFFFF_FFF0;
   endtask

   task automatic t_store_fault;
      preload(32'h60, 32'h0);
      preload(32'h64, 32'h0);
      err_addr = 32'h64;
      run_op(enc_sd(5'd14, 5'd7, 12'h010));
      chk("R8", "beat1 err cause", 32'(r_cause), 32'd7);
      chk("R8", "beat1 err beats", 32'(r_beats), 32'd2);
      chk("R8", "first word kept", mem_at(32'h60), 32'hC0C0_1414);
      chk("R8", "second word untouched", mem_at(32'h64), 32'h0);
      err_addr = 32'h60;
      run_op(enc_sd(5'd14, 5'd7, 12'h010));
      chk("R8", "beat0 err cause", 32'(r_cause), 32'd7);
      chk("R8", "beat0 err beats", 32'(r_beats), 32'd1);
      err_addr = 32'hFFFF_FFF0;
   endtask

   task automatic t_x0_load;
      run_op(enc_ld(5'd0, 5'd5, 12'd8));
      chk("R9", "x0 beats", 32'(r_beats), 32'd2);
      chk("R9", "x0 we", 32'(r_we), 32'd0);
      chk("R9", "x0 exc", 32'(r_exc), 32'd0);
   endtask

   task automatic t_handshake;
      int waited;
      @(negedge clk);
      issue_instr = enc_ld(5'd10, 5'd5, 12'd8);
      issue_valid = 1'b1;
      @(negedge clk);
      issue_valid = 1'b0;
      chk("R10", "busy after accept", 32'(issue_ready), 32'd0);
      waited = 0;
      while (!retire && waited < 50) begin
         @(negedge clk);
         waited++;
      end
      chk("R10", "retire seen", 32'(retire), 32'd1);
      @(negedge clk);
      chk("R10", "retire one cycle", 32'(retire), 32'd0);
      chk("R10", "ready after retire", 32'(issue_ready), 32'd1);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) regs[i] = 32'h0;
      regs[5]  = 32'h0000_0020;
      regs[6]  = 32'h0000_0040;
      regs[7]  = 32'h0000_0050;
      regs[8]  = 32'h4000_0000;
      regs[9]  = 32'h3FFF_FFFC;
      regs[14] = 32'hC0C0_1414;
      regs[15] = 32'hD0D0_1515;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_basic();
      t_load_negoff();
      t_store_basic();
      t_illegal();
      t_misaligned();
      t_region();
      t_load_fault();
      t_store_fault();
      t_x0_load();
      t_handshake();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule